// File: doc/BRIEF.md
# Storage Controller Interrupt Status Registers

This block collects the interrupt sources of a storage-interface controller and presents them to software through a small register bus. It has three registers: a pending register, an enable register and a write-only clear register. Two FIFO error conditions, overflow and underflow, are captured as sticky flags. Software clears them by writing 1 to the matching bit of the clear register. The drive's interrupt request line is not stored. It appears in two pending bits that always show the live level of that line. One of those bits feeds the CPU interrupt output and the other feeds the DMA interrupt output.

Software reads the pending register to find the cause of an interrupt. It unmasks sources through the enable register and acknowledges FIFO errors through the clear register. The bus is a simple strobe interface: one write strobe, one read strobe, a 2-bit word address, and read data that is registered. The addresses are pending = 0, enable = 1, clear = 2 and unused = 3.

Top module: `disk_irq_regs`

## Requirements
- R1: After reset the sticky flags and the enable register are 0, `reg_rdata` is 0, and both `cpu_irq` and `dma_irq` are low, whatever the level of `drive_irq`.
- R2: A pulse on `fifo_unf_evt` sets pending bit 7. The bit stays set in every later cycle until it is cleared through the clear register.
- R3: A pulse on `fifo_ovf_evt` sets pending bit 6. The bit stays set in every later cycle until it is cleared through the clear register.
- R4: A write to address 2 clears pending bit 7 and/or bit 6 where the write data holds a 1 at that position. Where the write data holds a 0, the flag is left unchanged.
- R5: When an error event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: The clear register is write-only. A read of address 2, or of the unused address 3, returns 0.
- R7: Pending bit 3 (CPU path) and pending bit 4 (DMA path) read as the current level of `drive_irq`. A write to the clear register never changes them.
- R8: `dma_irq` is high exactly when `drive_irq` is high and enable bit 4 is set.
- R9: `cpu_irq` is high exactly when at least one of pending bits 7, 6 and 3 is set together with the same enable bit.
- R10: A write to address 1 stores write-data bits 7, 6, 4 and 3 in the enable register. All other bits of the pending and enable registers read as 0, and writes to them have no effect.
- R11: `reg_rdata` is loaded on the clock edge that samples `reg_rd` and shows the addressed register's value as it was before that edge. When no read is made, `reg_rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| fifo_ovf_evt | input | 1 | FIFO overflow event, one cycle per event |
| fifo_unf_evt | input | 1 | FIFO underflow event, one cycle per event |
| drive_irq | input | 1 | Drive interrupt request level |
| cpu_irq | output | 1 | Masked interrupt to the CPU |
| dma_irq | output | 1 | Masked drive interrupt to the DMA engine |

## Verification
A sticky flag that is lost or stuck shows up in two places. The next read of the pending register returns a wrong value, and `cpu_irq` is wrong in the cycle right after the event or clear, provided the bit is enabled. A corrupt enable bit shows up on `cpu_irq` or `dma_irq` as soon as the matching source is active. The bench therefore compares both interrupt outputs in every cycle and compares the read data one cycle after each read strobe. Random traffic is mixed with directed event/clear collisions and writes to the clear register while the drive line is high.

// File: rtl/disk_irq_pkg.sv
package disk_irq_pkg;
   localparam int unsigned REG_W_DEF    = 8;
   localparam int unsigned ADDR_W_DEF   = 2;
   localparam int unsigned A_PEND_DEF   = 0;
   localparam int unsigned A_EN_DEF     = 1;
   localparam int unsigned A_CLR_DEF    = 2;
   localparam int unsigned UNF_BIT_DEF  = 7;
   localparam int unsigned OVF_BIT_DEF  = 6;
   localparam int unsigned DMA_BIT_DEF  = 4;
   localparam int unsigned CPU_BIT_DEF  = 3;
   localparam int unsigned NUM_STICKY   = 2;
   localparam int unsigned IDX_UNF      = 1;
   localparam int unsigned IDX_OVF      = 0;
endpackage

// File: rtl/disk_irq_sticky.sv
module disk_irq_sticky #(
   parameter int unsigned NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set_i,
   input  logic [NUM-1:0] clr_i,
   output logic [NUM-1:0] flag_o
);
   generate
      if (NUM < 1) begin : g_bad_num
         $error("disk_irq_sticky: NUM must be at least 1");
      end
      for (genvar g = 0; g < NUM; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[g] <= 1'b0;
            else if (set_i[g]) flag_o[g] <= 1'b1;
            else if (clr_i[g]) flag_o[g] <= 1'b0;
         end

         // R2 and R3: a set flag survives until a clear arrives
         assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
         assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]);
         assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
      end
   endgenerate
endmodule

// File: rtl/disk_irq_enable.sv
module disk_irq_enable #(
   parameter int unsigned W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_o <= '0;
      else if (we_i) en_o <= d_i & MASK;
   end

   assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(en_o));
endmodule

// File: rtl/disk_irq_rdport.sv
module disk_irq_rdport #(
   parameter int unsigned W      = 8,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned A_PEND = 0,
   parameter int unsigned A_EN   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [W-1:0]      pend_i,
   input  logic [W-1:0]      en_i,
   output logic [W-1:0]      rdata_o
);
   logic [W-1:0] sel;

   always_comb begin
      if (addr_i == ADDR_W'(A_PEND))    sel = pend_i;
      else if (addr_i == ADDR_W'(A_EN)) sel = en_i;
      else                              sel = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= sel;
   end

   assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/disk_irq_regs.sv
module disk_irq_regs
   import disk_irq_pkg::*;
#(
   parameter int unsigned REG_W   = REG_W_DEF,
   parameter int unsigned ADDR_W  = ADDR_W_DEF,
   parameter int unsigned A_PEND  = A_PEND_DEF,
   parameter int unsigned A_EN    = A_EN_DEF,
   parameter int unsigned A_CLR   = A_CLR_DEF,
   parameter int unsigned UNF_BIT = UNF_BIT_DEF,
   parameter int unsigned OVF_BIT = OVF_BIT_DEF,
   parameter int unsigned DMA_BIT = DMA_BIT_DEF,
   parameter int unsigned CPU_BIT = CPU_BIT_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              fifo_ovf_evt,
   input  logic              fifo_unf_evt,
   input  logic              drive_irq,
   output logic              cpu_irq,
   output logic              dma_irq
);
   localparam logic [REG_W-1:0] ONE      = {{(REG_W-1){1'b0}}, 1'b1};
   localparam logic [REG_W-1:0] M_UNF    = ONE << UNF_BIT;
   localparam logic [REG_W-1:0] M_OVF    = ONE << OVF_BIT;
   localparam logic [REG_W-1:0] M_DMA    = ONE << DMA_BIT;
   localparam logic [REG_W-1:0] M_CPU    = ONE << CPU_BIT;
   localparam logic [REG_W-1:0] VALID    = M_UNF | M_OVF | M_DMA | M_CPU;
   localparam logic [REG_W-1:0] CPU_SRCS = M_UNF | M_OVF | M_CPU;

   generate
      if (UNF_BIT >= REG_W || OVF_BIT >= REG_W || DMA_BIT >= REG_W || CPU_BIT >= REG_W) begin : g_bad_pos
         $error("disk_irq_regs: bit position outside register width");
      end
      if ((1 << ADDR_W) <= A_PEND || (1 << ADDR_W) <= A_EN || (1 << ADDR_W) <= A_CLR) begin : g_bad_addr
         $error("disk_irq_regs: register address outside address range");
      end
      if (A_PEND == A_EN || A_PEND == A_CLR || A_EN == A_CLR) begin : g_dup_addr
         $error("disk_irq_regs: register addresses must differ");
      end
   endgenerate

   logic                  wr_en_sel;
   logic                  wr_clr_sel;
   logic [NUM_STICKY-1:0] evt_vec;
   logic [NUM_STICKY-1:0] clr_vec;
   logic [NUM_STICKY-1:0] flag_q;
   logic [REG_W-1:0]      en_q;
   logic [REG_W-1:0]      pend;

   assign wr_en_sel  = reg_wr && (reg_addr == ADDR_W'(A_EN));
   assign wr_clr_sel = reg_wr && (reg_addr == ADDR_W'(A_CLR));

   always_comb begin
      evt_vec          = '0;
      clr_vec          = '0;
      evt_vec[IDX_UNF] = fifo_unf_evt;
      evt_vec[IDX_OVF] = fifo_ovf_evt;
      clr_vec[IDX_UNF] = wr_clr_sel && reg_wdata[UNF_BIT];
      clr_vec[IDX_OVF] = wr_clr_sel && reg_wdata[OVF_BIT];
   end

   disk_irq_sticky #(.NUM(NUM_STICKY)) u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_vec),
      .clr_i  (clr_vec),
      .flag_o (flag_q)
   );

   disk_irq_enable #(.W(REG_W), .MASK(VALID)) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_en_sel),
      .d_i   (reg_wdata),
      .en_o  (en_q)
   );

   always_comb begin
      pend          = '0;
      pend[UNF_BIT] = flag_q[IDX_UNF];
      pend[OVF_BIT] = flag_q[IDX_OVF];
      pend[CPU_BIT] = drive_irq;
      pend[DMA_BIT] = drive_irq;
   end

   disk_irq_rdport #(.W(REG_W), .ADDR_W(ADDR_W), .A_PEND(A_PEND), .A_EN(A_EN)) u_rdport (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (reg_rd),
      .addr_i  (reg_addr),
      .pend_i  (pend),
      .en_i    (en_q),
      .rdata_o (reg_rdata)
   );

   assign cpu_irq = |(pend & en_q & CPU_SRCS);
   assign dma_irq = pend[DMA_BIT] & en_q[DMA_BIT];

   assert_cpu_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & CPU_SRCS) == '0) |-> !cpu_irq);
   assert_dma_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_irq |-> drive_irq);
   assert_clr_wo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(A_CLR)) |=> (reg_rdata == '0));
   assert_drv_ignores_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_irq && en_q[CPU_BIT]) |-> cpu_irq);
endmodule

// File: tb/tb_disk_irq_regs.sv
`timescale 1ns/1ps
module tb_disk_irq_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       fifo_ovf_evt = 1'b0, fifo_unf_evt = 1'b0, drive_irq = 1'b0;
   logic       cpu_irq, dma_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   bit       m_unf = 0, m_ovf = 0;
   bit [7:0] m_en = '0;
   bit [7:0] m_rd = '0;

   always #2 clk = ~clk;

   disk_irq_regs dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fifo_ovf_evt(fifo_ovf_evt), .fifo_unf_evt(fifo_unf_evt),
      .drive_irq(drive_irq), .cpu_irq(cpu_irq), .dma_irq(dma_irq)
   );

   function automatic bit [7:0] f_pend(bit unf, bit ovf, bit drv);
      return {unf, ovf, 1'b0, drv, drv, 3'b000};
   endfunction

   function automatic bit [7:0] f_read(bit [1:0] a, bit unf, bit ovf, bit drv, bit [7:0] en);
      case (a)
         2'd0: return f_pend(unf, ovf, drv);
         2'd1: return en;
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit f_cpu(bit unf, bit ovf, bit drv, bit [7:0] en);
      return |(f_pend(unf, ovf, drv) & en & 8'hC8);
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One bus cycle: drive inputs, check live outputs, clock, check read data.
   task automatic cyc(string tag, bit ovf, bit unf, bit drv, bit wr, bit rd,
                      bit [1:0] a, bit [7:0] wd);
      bit [7:0] clr;
      fifo_ovf_evt = ovf; fifo_unf_evt = unf; drive_irq = drv;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      #1;
      check({tag, " R9 cpu_irq"}, {7'd0, cpu_irq}, {7'd0, f_cpu(m_unf, m_ovf, drv, m_en)});
      check({tag, " R8 dma_irq"}, {7'd0, dma_irq}, {7'd0, drv & m_en[4]});
      if (rd) m_rd = f_read(a, m_unf, m_ovf, drv, m_en);
      clr = (wr && a == 2'd2) ? wd : 8'h00;
      m_unf = unf | (m_unf & ~clr[7]);
      m_ovf = ovf | (m_ovf & ~clr[6]);
      if (wr && a == 2'd1) m_en = wd & 8'hD8;
      @(posedge clk); #1;
      check({tag, " R11 rdata"}, reg_rdata, m_rd);
   endtask

   task automatic idle(string tag, bit drv);
      cyc(tag, 0, 0, drv, 0, 0, 2'd0, 8'h00);
   endtask

   task automatic rd(string tag, bit drv, bit [1:0] a);
      cyc(tag, 0, 0, drv, 0, 1, a, 8'h00);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      drive_irq = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state with drive line high
      check("R1 rdata", reg_rdata, 8'h00);
      check("R1 cpu_irq", {7'd0, cpu_irq}, 8'h00);
      check("R1 dma_irq", {7'd0, dma_irq}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); #1;
      rd("R1 en", 1, 2'd1);
      check("R1 enable zero", reg_rdata, 8'h00);

      // R2: underflow sticky
      cyc("R2", 0, 1, 0, 0, 0, 2'd0, 8'h00);
      idle("R2", 0); idle("R2", 0);
      rd("R2", 0, 2'd0);
      check("R2 pend unf", reg_rdata, 8'h80);
      // R4: a 0 in the clear data keeps the flag
      cyc("R4", 0, 0, 0, 1, 0, 2'd2, 8'h40);
      rd("R4", 0, 2'd0);
      check("R4 unf kept", reg_rdata, 8'h80);
      cyc("R4", 0, 0, 0, 1, 0, 2'd2, 8'h80);
      rd("R4", 0, 2'd0);
      check("R4 unf cleared", reg_rdata, 8'h00);

      // R3: overflow sticky
      cyc("R3", 1, 0, 0, 0, 0, 2'd0, 8'h00);
      idle("R3", 0);
      rd("R3", 0, 2'd0);
      check("R3 pend ovf", reg_rdata, 8'h40);
      // R5: event and clear together, event wins
      cyc("R5", 1, 1, 0, 1, 0, 2'd2, 8'hFF);
      rd("R5", 0, 2'd0);
      check("R5 set wins", reg_rdata, 8'hC0);

      // R6: clear and unused addresses read 0
      rd("R6", 0, 2'd2);
      check("R6 clr read", reg_rdata, 8'h00);
      rd("R6", 1, 2'd3);
      check("R6 unused read", reg_rdata, 8'h00);

      // R10: enable keeps only valid bits
      cyc("R10", 0, 0, 0, 1, 0, 2'd1, 8'hFF);
      rd("R10", 0, 2'd1);
      check("R10 en mask", reg_rdata, 8'hD8);
      cyc("R4", 0, 0, 0, 1, 0, 2'd2, 8'hC0);

      // R7: drive level in bits 3 and 4, clear has no effect
      cyc("R7", 0, 0, 1, 1, 0, 2'd2, 8'hFF);
      rd("R7", 1, 2'd0);
      check("R7 drv bits", reg_rdata, 8'h18);
      rd("R7", 0, 2'd0);
      check("R7 drv low", reg_rdata, 8'h00);

      // R8 / R9: single enables
      cyc("R8", 0, 0, 0, 1, 0, 2'd1, 8'h10);
      idle("R8", 1);
      check("R8 dma only", {6'd0, cpu_irq, dma_irq}, 8'h01);
      cyc("R9", 0, 0, 0, 1, 0, 2'd1, 8'h08);
      idle("R9", 1);
      check("R9 cpu only", {6'd0, cpu_irq, dma_irq}, 8'h02);

      // R11: data holds without a read
      rd("R11", 1, 2'd1);
      idle("R11", 0); idle("R11", 1);
      check("R11 hold", reg_rdata, 8'h08);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         bit [31:0] r = $urandom;
         cyc("RND", r[0] & r[1] & r[2], r[3] & r[4] & r[5], r[6] | r[7],
             r[8] & r[9], r[10], r[12:11], r[20:13]);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule